// File: doc/BRIEF.md
# Split/Joined PWM Timer

This block generates pulse-width modulated waveforms from a single counter that feeds on one shared, programmable clock prescaler. Software can treat the counter as two independent 8-bit byte lanes. Each lane is then its own PWM channel, with its own period, its own duty value and its own run bit. Software can instead join the two lanes into one 16-bit counter that drives both outputs from a single 16-bit period and duty pair. Each output has a polarity bit. That bit inverts the waveform while the channel runs, and it sets the idle level while the channel is stopped.

Period and duty writes land in shadow registers. They are copied into the active compare registers when the counter wraps, so a waveform is never cut in the middle of a period. When a channel is stopped, the copy happens at once. Stopping a channel freezes its counter value. The shared prescaler is cleared only once every channel is stopped. Software may write the counter directly only while both run bits are clear.

Top module: `pwm_pair_timer`

## Requirements
- R1: Control register (address 0) layout: bits [1:0] mode, bit 2 run_a, bit 3 run_b, bit 4 pol_a, bit 5 pol_b. Mode 01 is split (two 8-bit channels) and mode 10 is joined (one 16-bit channel). In modes 00 and 11 the counter never advances and each output holds its polarity bit.
- R2: The prescaler divider (address 1, bits [7:0]) value D produces one counter advance every D+1 clock cycles while any channel runs.
- R3: In split mode, lane A is count_o[7:0] with period/duty bits [7:0] of addresses 3/4, and lane B is count_o[15:8] with bits [15:8]. With period P and duty W (W ≤ P, polarity 0), each lane counts 0..P and its output is high for W of every P+1 advances. The output rises on the advance from 0 to 1.
- R4: A lane whose count is above its period counts up to all ones (0xFF) and then wraps to 0.
- R5: A write to the counter register (address 2) takes effect only when both run bits in the control register are clear. Otherwise it is discarded.
- R6: While a channel is stopped, its output equals its polarity bit and its counter keeps its last value.
- R7: Period and duty writes take effect at the next counter wrap of a running channel. A period that is already under way completes with the old value. A stopped channel takes new values immediately.
- R8: The prescaler phase is cleared when both channels are stopped, so after a restart the first advance comes D+1 clocks later. The phase is not cleared while any channel runs.
- R9: In joined mode the two lanes form one 16-bit counter that carries from lane A into lane B. Only run_a starts and stops it, and run_b has no effect.
- R10: In joined mode both outputs carry the same waveform, each XORed with its own polarity bit, so opposite polarity bits give complementary outputs.
- R11: Setting a polarity bit while the channel runs inverts that channel's output waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 control, 1 divider, 2 counter, 3 period, 4 duty |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 16 | Current counter value, lane B in the upper byte |
| pwm_a_o | output | 1 | PWM output of channel A |
| pwm_b_o | output | 1 | PWM output of channel B |

## Verification
The main waveform check runs two split lanes with different periods and duties at the same time. A window that spans whole periods of both lanes is counted, which separates lane crosstalk and off-by-one period or duty errors. The same window is repeated with inverted polarity. It is repeated again with a divider of 2, which shows that the divider stretches every advance evenly. The joined mode runs with a period above 255, a duty of 128 and opposite polarity bits; this exposes a missing byte carry, a wrong wrap point and any sample where the two outputs are not complementary. Separate directed patterns cover a counter preloaded above the period, a period rewrite in mid-period, a stop and restart that lands on a non-zero prescaler phase, and counter writes made while a run bit is set.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int LANES  = 2;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_WIDE = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  typedef struct packed {
    logic  pol_b;
    logic  pol_a;
    logic  run_b;
    logic  run_a;
    mode_e mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PER   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DUTY  = 3'd4;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRESC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [PRESC_W-1:0] div_o,
  output logic [DATA_W-1:0] per_sh_o,
  output logic [DATA_W-1:0] duty_sh_o,
  output logic              cnt_we_o,
  output logic [DATA_W-1:0] cnt_wdata_o
);
  ctrl_t              ctrl_q;
  logic [PRESC_W-1:0] div_q;
  logic [DATA_W-1:0]  per_q, duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        ADDR_DIV:  div_q  <= wdata_i[PRESC_W-1:0];
        ADDR_PER:  per_q  <= wdata_i;
        ADDR_DUTY: duty_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // counter writes are dropped while either run bit is set
  assign cnt_we_o    = we_i && (addr_i == ADDR_COUNT) && !ctrl_q.run_a && !ctrl_q.run_b;
  assign cnt_wdata_o = wdata_i;
  assign ctrl_o      = ctrl_q;
  assign div_o       = div_q;
  assign per_sh_o    = per_q;
  assign duty_sh_o   = duty_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] div_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r8_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

  a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         upd_i,
  input  logic [W-1:0] per_sh_i,
  input  logic [W-1:0] duty_sh_i,
  output logic [W-1:0] cnt_o,
  output logic         eq_per_o,
  output logic         eq_duty_o,
  output logic         zero_o,
  output logic         ones_o
);
  logic [W-1:0] cnt_q, per_q, duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_i)  cnt_q <= clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (upd_i) begin
      per_q  <= per_sh_i;
      duty_q <= duty_sh_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign eq_per_o  = (cnt_q == per_q);
  assign eq_duty_o = (cnt_q == duty_q);
  assign zero_o    = (cnt_q == '0);
  assign ones_o    = &cnt_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(cnt_q));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !load_i && cnt_q == '1) |=> cnt_q == '0);

  a_r7_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(per_q) && $stable(duty_q)));
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  ctrl_t             ctrl_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] per_sh_i,
  input  logic [DATA_W-1:0] duty_sh_i,
  output logic              run_any_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [LANES-1:0]  pwm_o
);
  logic             wide, dual;
  logic [LANES-1:0] run, pol, act, lane_act;
  logic [LANES-1:0] eq_per, eq_duty, zero, ones, carry;
  logic [LANES-1:0] adv, clr, upd, raw_q;
  logic             wrap_wide;

  assign wide      = (ctrl_i.mode == MODE_WIDE);
  assign dual      = (ctrl_i.mode == MODE_DUAL);
  assign run       = {ctrl_i.run_b, ctrl_i.run_a};
  assign pol       = {ctrl_i.pol_b, ctrl_i.pol_a};
  assign wrap_wide = (&eq_per) | (&ones);
  assign run_any_o = |act;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_c0
      assign act[g]   = (dual || wide) && run[g];
      assign carry[g] = 1'b1;
    end else begin : g_cn
      assign act[g]   = dual && run[g];
      assign carry[g] = carry[g-1] & ones[g-1];
    end

    assign lane_act[g] = wide ? act[0] : act[g];
    assign clr[g]      = wide ? wrap_wide : (eq_per[g] | ones[g]);
    assign adv[g]      = tick_i && lane_act[g] && (!wide || carry[g] || wrap_wide);
    // stopped lanes follow the shadows; running lanes reload only on wrap
    assign upd[g]      = !lane_act[g] || (tick_i && clr[g]);

    pwm_lane #(.W(LANE_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adv_i      (adv[g]),
      .clr_i      (clr[g]),
      .load_i     (load_i),
      .load_val_i (load_val_i[g*LANE_W +: LANE_W]),
      .upd_i      (upd[g]),
      .per_sh_i   (per_sh_i[g*LANE_W +: LANE_W]),
      .duty_sh_i  (duty_sh_i[g*LANE_W +: LANE_W]),
      .cnt_o      (cnt_o[g*LANE_W +: LANE_W]),
      .eq_per_o   (eq_per[g]),
      .eq_duty_o  (eq_duty[g]),
      .zero_o     (zero[g]),
      .ones_o     (ones[g])
    );

    logic hit_duty, hit_zero;
    assign hit_duty = wide ? (&eq_duty) : eq_duty[g];
    assign hit_zero = wide ? (&zero)    : zero[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               raw_q[g] <= 1'b0;
      else if (!act[g])          raw_q[g] <= 1'b0;
      else if (tick_i) begin
        if (hit_duty)            raw_q[g] <= 1'b0;
        else if (hit_zero)       raw_q[g] <= 1'b1;
      end
    end

    localparam int SRC = g;
    logic src_act, src_raw;
    assign src_act = wide ? act[0]   : act[SRC];
    assign src_raw = wide ? raw_q[0] : raw_q[SRC];
    assign pwm_o[g] = src_act ? (src_raw ^ pol[g]) : pol[g];
  end

  a_r10_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide |-> ((pwm_o[0] ^ pwm_o[1]) == (pol[0] ^ pol[1])));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int PRESC_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] count_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  ctrl_t              ctrl;
  logic [PRESC_W-1:0] div;
  logic [DATA_W-1:0]  per_sh, duty_sh, cnt_wdata;
  logic               cnt_we, run_any, tick;
  logic [LANES-1:0]   pwm;

  pwm_regs #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (wr_en_i),
    .addr_i      (wr_addr_i),
    .wdata_i     (wr_data_i),
    .ctrl_o      (ctrl),
    .div_o       (div),
    .per_sh_o    (per_sh),
    .duty_sh_o   (duty_sh),
    .cnt_we_o    (cnt_we),
    .cnt_wdata_o (cnt_wdata)
  );

  pwm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_any),
    .div_i  (div),
    .tick_o (tick)
  );

  pwm_core #(.LANE_W(LANE_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .ctrl_i     (ctrl),
    .load_i     (cnt_we),
    .load_val_i (cnt_wdata),
    .per_sh_i   (per_sh),
    .duty_sh_i  (duty_sh),
    .run_any_o  (run_any),
    .cnt_o      (count_o),
    .pwm_o      (pwm)
  );

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];

  a_r5_count_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_COUNT && (ctrl.run_a || ctrl.run_b) && !tick)
      |=> $stable(count_o));
endmodule

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pwm_a, pwm_b;

  always #2.5 clk = ~clk;

  pwm_pair_timer uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .count_o   (count),
    .pwm_a_o   (pwm_a),
    .pwm_b_o   (pwm_b)
  );

  localparam int S_A = 0, S_B = 1, S_CNT = 2, S_LO = 3, S_HI = 4, S_MEAS = 5;

  typedef struct {
    string req;
    int    sel;
    int    expv;
    int    actv;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  task automatic expect_sig(input string req, input int sel, input int v);
    item_t it;
    it.req = req; it.sel = sel; it.expv = v; it.actv = 0;
    q.push_back(it);
  endtask

  task automatic expect_meas(input string req, input int act, input int v);
    item_t it;
    it.req = req; it.sel = S_MEAS; it.expv = v; it.actv = act;
    q.push_back(it);
  endtask

  // monitor: compares queued items just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        int    a;
        it = q.pop_front();
        case (it.sel)
          S_A:     a = int'(pwm_a);
          S_B:     a = int'(pwm_b);
          S_CNT:   a = int'(count);
          S_LO:    a = int'(count[7:0]);
          S_HI:    a = int'(count[15:8]);
          default: a = it.actv;
        endcase
        n_tests++;
        if (a != it.expv) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, a, it.expv);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic nwait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int n, output int ha, output int hb, output int same);
    ha = 0; hb = 0; same = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_a) ha++;
      if (pwm_b) hb++;
      if (pwm_a == pwm_b) same++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ha, hb, same, v;
    nwait(3);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    expect_sig("R6 reset out a", S_A, 0);
    expect_sig("R6 reset out b", S_B, 0);
    expect_sig("R6 reset count", S_CNT, 0);

    // mode 00 with run bits set: idle at polarity, counter still
    wr(3'd0, 16'h003C);
    nwait(3);
    expect_sig("R1 off mode count", S_CNT, 0);
    expect_sig("R1 off mode out a", S_A, 1);
    expect_sig("R1 off mode out b", S_B, 1);
    wr(3'd2, 16'h1234);
    @(negedge clk);
    expect_sig("R5 count write with run bits", S_CNT, 0);

    // split mode, two lanes
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0503);
    wr(3'd4, 16'h0201);
    wr(3'd0, 16'h000D);
    expect_sig("R3 start count", S_CNT, 0);
    @(negedge clk);
    expect_sig("R3 first advance count", S_CNT, 16'h0101);
    expect_sig("R3 rise on 0 to 1 a", S_A, 1);
    expect_sig("R3 rise on 0 to 1 b", S_B, 1);
    measure(24, ha, hb, same);
    expect_meas("R3 lane a duty", ha, 6);
    expect_meas("R3 lane b duty", hb, 8);

    wr(3'd0, 16'h003D);
    measure(24, ha, hb, same);
    expect_meas("R11 inverted a", ha, 18);
    expect_meas("R11 inverted b", hb, 16);

    // stop lane a, b keeps running
    wr(3'd0, 16'h0039);
    v = int'(count[7:0]);
    expect_sig("R6 stopped a idle level", S_A, 1);
    wr(3'd2, 16'hABCD);
    @(negedge clk);
    expect_sig("R6 lane a frozen", S_LO, v);
    expect_meas("R5 write dropped while b runs", int'(count[15:8] == 8'hAB), 0);

    // all stopped: counter write allowed
    wr(3'd0, 16'h0001);
    expect_sig("R6 stopped a pol 0", S_A, 0);
    expect_sig("R6 stopped b pol 0", S_B, 0);
    wr(3'd2, 16'h2233);
    expect_sig("R5 write while stopped", S_CNT, 16'h2233);

    // count above period runs to 0xFF then 0
    wr(3'd2, 16'h0010);
    wr(3'd0, 16'h0005);
    nwait(239);
    expect_sig("R4 reaches all ones", S_LO, 8'hFF);
    @(negedge clk);
    expect_sig("R4 wraps to zero", S_LO, 0);
    expect_sig("R6 idle lane b frozen", S_HI, 0);

    // period rewrite mid-period
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0005);
    wr(3'd3, 16'h0505);
    nwait(3);
    expect_sig("R7 old period completes", S_LO, 0);
    nwait(5);
    expect_sig("R7 new period reached", S_LO, 5);
    @(negedge clk);
    expect_sig("R7 new period wrap", S_LO, 0);

    // prescaler divide by 3
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0503);
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0005);
    measure(36, ha, hb, same);
    expect_meas("R2 divided duty a", ha, 9);

    // prescaler phase cleared on full stop
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0005);
    @(negedge clk);
    expect_sig("R2 no advance yet", S_LO, 0);
    @(negedge clk);
    expect_sig("R2 no advance yet 2", S_LO, 0);
    @(negedge clk);
    expect_sig("R2 advance after 3 clocks", S_LO, 1);
    wr(3'd0, 16'h0001);
    expect_sig("R6 frozen at stop", S_LO, 1);
    wr(3'd0, 16'h0005);
    nwait(2);
    expect_sig("R8 phase restarted", S_LO, 1);
    @(negedge clk);
    expect_sig("R8 first advance after restart", S_LO, 2);

    // joined 16-bit mode, complementary outputs
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0102);
    wr(3'd4, 16'h0080);
    wr(3'd0, 16'h0026);
    @(negedge clk);
    nwait(255);
    expect_sig("R9 carry into upper byte", S_CNT, 16'h0100);
    nwait(2);
    expect_sig("R9 wide period top", S_CNT, 16'h0102);
    @(negedge clk);
    expect_sig("R9 wide wrap", S_CNT, 0);
    measure(518, ha, hb, same);
    expect_meas("R10 wide duty a", ha, 256);
    expect_meas("R10 wide complement b", hb, 262);
    expect_meas("R10 outputs never equal", same, 0);

    // run_b alone does nothing in joined mode
    wr(3'd0, 16'h002A);
    v = int'(count);
    nwait(3);
    expect_sig("R9 run_b ignored count", S_CNT, v);
    expect_sig("R9 stopped a level", S_A, 0);
    expect_sig("R9 stopped b level", S_B, 1);
    wr(3'd2, 16'h5555);
    expect_sig("R5 write dropped run_b set", S_CNT, v);

    nwait(3);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule